// File: doc/BRIEF.md
# Windowed Threshold Interrupt with Persistence

This block watches a stream of conversion results and raises an interrupt when the results stay outside a programmable window for long enough. Each accepted result is compared with a low and a high bound. A result below the low bound or above the high bound is an out-of-window event. The block counts consecutive events. When the count reaches the length selected by a 2-bit persistence code, it sets a sticky flag and enables the active-low open-drain interrupt driver.

The flag stays set until the host reads the command register. That read reaches this block as a one-cycle clear pulse. The host should also pulse the clear after it changes a threshold. Storing the thresholds and decoding the bus are done outside this block.

Results arrive on a valid-qualified input with no ready signal. The block accepts every beat on which `res_valid` is high and never applies back-pressure. Cycles with `res_valid` low are idle cycles: they neither add to a run nor break it.

Top module: `win_irq_persist`

## Requirements
- R1: A valid result counts as an event only if it is strictly below `thr_lo` or strictly above `thr_hi`. A result equal to either bound is in the window.
- R2: The run length needed to fire depends on `pers_code`: 2'b00 needs 1 consecutive event, 2'b01 needs 4, 2'b10 needs 8 and 2'b11 needs 16.
- R3: A valid in-window result resets the consecutive-event run to zero.
- R4: On the clock edge that samples the event completing the required run, `irq_flag` goes to 1 and `irq_pin_oe` goes to 1 (pin pulled low). Both are visible after that edge.
- R5: Once set, `irq_flag` and `irq_pin_oe` stay at 1 through any later results and idle cycles until `flag_clr` is sampled high.
- R6: A `flag_clr` pulse also resets the consecutive-event run to zero.
- R7: If `flag_clr` and a run-completing event are sampled on the same edge, the flag ends up set.
- R8: After reset, `irq_flag` is 0, `irq_pin_oe` is 0 and the run is zero.
- R9: Cycles with `res_valid` low leave the run unchanged. Events separated only by idle cycles still count as consecutive.
- R10: With `thr_lo` = 16'h0000 and `thr_hi` = 16'hFFFF, no result is an event and the flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A new conversion result is present this cycle |
| res_data | input | DATA_W | Conversion result value |
| thr_lo | input | DATA_W | Low bound of the window |
| thr_hi | input | DATA_W | High bound of the window |
| pers_code | input | 2 | Persistence selector (1, 4, 8 or 16 events) |
| flag_clr | input | 1 | One-cycle clear from a read of the command register |
| irq_flag | output | 1 | Sticky interrupt status bit |
| irq_pin_oe | output | 1 | Enables the open-drain driver that pulls the interrupt pin low |

## Verification
The bench builds the block with its default parameters: a 16-bit data width and a run counter that saturates at 16. The full 16-bit range makes both extremes of the default window (0x0000 and 0xFFFF) reachable as stimulus. The saturation limit lets the bench drive runs longer than the longest persistence setting. The bench also drives the exact bound values, runs broken by in-window results, runs broken by a clear, and runs interleaved with idle cycles. It pulses a clear on the same edge as a completing event.

// File: rtl/wip_pkg.sv
package wip_pkg;
  localparam int PCODE_W = 2;
  localparam int RUN_MAX = 16;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  function automatic logic [RUN_W-1:0] run_needed(input logic [PCODE_W-1:0] code);
    logic [RUN_W-1:0] n;
    case (code)
      2'b00:   n = RUN_W'(1);
      2'b01:   n = RUN_W'(4);
      2'b10:   n = RUN_W'(8);
      default: n = RUN_W'(16);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/wip_window_cmp.sv
module wip_window_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  output logic              out_evt,
  output logic              in_evt
);
  logic below, above;

  always_comb begin
    below   = sample < lo;
    above   = sample > hi;
    out_evt = valid && (below || above);
    in_evt  = valid && !(below || above);
  end

  // R10: the widest window never yields an event
  always_comb begin
    if (valid && lo == '0 && hi == '1)
      assert_full_window_quiet_R10: assert (!out_evt);
  end
endmodule

// File: rtl/wip_run_ctr.sv
module wip_run_ctr
  import wip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_evt,
  input  logic             in_evt,
  input  logic             clr,
  input  logic [RUN_W-1:0] need,
  output logic             reach
);
  logic [RUN_W-1:0] run_q;
  logic [RUN_W:0]   run_inc;

  always_comb begin
    run_inc = {1'b0, run_q} + 1'b1;
    reach   = out_evt && (run_inc >= {1'b0, need});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (clr || in_evt)
      run_q <= '0;
    else if (out_evt && run_q != RUN_W'(RUN_MAX))
      run_q <= run_inc[RUN_W-1:0];
  end

  assert_inwin_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_evt |=> run_q == '0);
  assert_clr_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> run_q == '0);
  assert_run_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(RUN_MAX));
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_evt && !in_evt && !clr) |=> $stable(run_q));
endmodule

// File: rtl/wip_flag_latch.sv
module wip_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (set)
      flag <= 1'b1;
    else if (clr)
      flag <= 1'b0;
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/win_irq_persist.sv
module win_irq_persist
  import wip_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_valid,
  input  logic [DATA_W-1:0]  res_data,
  input  logic [DATA_W-1:0]  thr_lo,
  input  logic [DATA_W-1:0]  thr_hi,
  input  logic [PCODE_W-1:0] pers_code,
  input  logic               flag_clr,
  output logic               irq_flag,
  output logic               irq_pin_oe
);
  logic             out_evt, in_evt, reach, flag;
  logic [RUN_W-1:0] need;

  assign need = run_needed(pers_code);

  wip_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .valid(res_valid), .sample(res_data), .lo(thr_lo), .hi(thr_hi),
    .out_evt(out_evt), .in_evt(in_evt)
  );

  wip_run_ctr u_run (
    .clk(clk), .rst_n(rst_n), .out_evt(out_evt), .in_evt(in_evt),
    .clr(flag_clr), .need(need), .reach(reach)
  );

  wip_flag_latch u_flag (
    .clk(clk), .rst_n(rst_n), .set(reach), .clr(flag_clr), .flag(flag)
  );

  assign irq_flag   = flag;
  assign irq_pin_oe = flag;

  // R4: the flag only rises on an edge that sampled an out-of-window result
  assert_rise_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(res_valid && (res_data < thr_lo || res_data > thr_hi)));
  // R1: a result on a bound cannot complete a run
  assert_bound_inside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_data == thr_lo || res_data == thr_hi) && !irq_flag) |=> !irq_flag);
endmodule

// File: tb/win_irq_persist_test.sv
`timescale 1ns/1ps
module win_irq_persist_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic [15:0] thr_lo = 16'h0000;
  logic [15:0] thr_hi = 16'hFFFF;
  logic [1:0]  pers_code = 2'b00;
  logic        flag_clr = 1'b0;
  logic        irq_flag, irq_pin_oe;

  int  vectors = 0;
  int  fails = 0;
  int  m_run = 0;
  bit  m_flag = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  win_irq_persist #(.DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .pers_code(pers_code),
    .flag_clr(flag_clr), .irq_flag(irq_flag), .irq_pin_oe(irq_pin_oe)
  );

  function automatic int needed(input logic [1:0] c);
    if (c == 2'b00) return 1;
    if (c == 2'b01) return 4;
    if (c == 2'b10) return 8;
    return 16;
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (irq_flag !== m_flag || irq_pin_oe !== m_flag) begin
      fails++;
      $display("FAIL %s: flag=%0b pin_oe=%0b expected %0b", tag, irq_flag, irq_pin_oe, m_flag);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] d, input logic c, input string tag);
    bit outside, hit;
    res_valid = v; res_data = d; flag_clr = c;
    @(posedge clk);
    outside = v && ((d < thr_lo) || (d > thr_hi));
    hit = outside && (m_run + 1 >= needed(pers_code));
    if (hit) m_flag = 1;
    else if (c) m_flag = 0;
    if (c || (v && !outside)) m_run = 0;
    else if (outside && m_run < 16) m_run = m_run + 1;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic events(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 16'd5, 1'b0, tag);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R8 reset state");
    rst_n = 1'b1;
    step(1'b0, 16'd0, 1'b0, "R8 after reset");

    // R10: default window never fires
    step(1'b1, 16'h0000, 1'b0, "R10 low extreme");
    step(1'b1, 16'hFFFF, 1'b0, "R10 high extreme");
    step(1'b1, 16'h1234, 1'b0, "R10 mid value");

    // R1 bounds, R4 fire, R5 sticky
    thr_lo = 16'd100; thr_hi = 16'd200; flag_clr = 1'b1;
    step(1'b0, 16'd0, 1'b1, "R6 clear after threshold change");
    step(1'b1, 16'd100, 1'b0, "R1 equal to low bound");
    step(1'b1, 16'd200, 1'b0, "R1 equal to high bound");
    step(1'b1, 16'd99, 1'b0, "R4 below low fires");
    step(1'b1, 16'd150, 1'b0, "R5 sticky through in-window");
    step(1'b0, 16'd0, 1'b0, "R5 sticky while idle");
    step(1'b0, 16'd0, 1'b1, "R5 clear");
    step(1'b1, 16'd201, 1'b0, "R1 above high fires");
    step(1'b0, 16'd0, 1'b1, "R5 clear");

    // R2 code 01 with R3 in-window reset
    pers_code = 2'b01;
    events(3, "R2 three of four");
    step(1'b1, 16'd150, 1'b0, "R3 in-window breaks run");
    events(3, "R3 run restarted");
    events(1, "R2 fourth event fires");
    step(1'b0, 16'd0, 1'b1, "R5 clear");

    // R9 idle cycles do not break the run
    events(2, "R9 first half");
    for (int i = 0; i < 3; i++) step(1'b0, 16'd150, 1'b0, "R9 idle gap");
    events(2, "R9 completes across gap");
    step(1'b0, 16'd0, 1'b1, "R5 clear");

    // R6 clear resets the run
    events(3, "R6 before clear");
    step(1'b0, 16'd0, 1'b1, "R6 clear mid-run");
    events(3, "R6 run restarted");
    events(1, "R6 fires after four");
    step(1'b0, 16'd0, 1'b1, "R5 clear");

    // R2 codes 10 and 11, plus saturation
    pers_code = 2'b10;
    events(8, "R2 eight events");
    step(1'b0, 16'd0, 1'b1, "R5 clear");
    pers_code = 2'b11;
    events(15, "R2 fifteen of sixteen");
    events(5, "R2 sixteen and beyond");
    step(1'b0, 16'd0, 1'b1, "R5 clear");

    // R7 set beats clear on the same edge
    pers_code = 2'b00;
    events(1, "R7 flag set");
    step(1'b1, 16'd5, 1'b1, "R7 clear with completing event");
    pers_code = 2'b01;
    step(1'b1, 16'd5, 1'b1, "R7 clear with non-completing event");
    events(3, "R6 clear counted as restart");
    step(1'b0, 16'd0, 1'b1, "R5 clear");

    // R10 again after restoring defaults
    thr_lo = 16'h0000; thr_hi = 16'hFFFF; pers_code = 2'b00;
    step(1'b1, 16'h0000, 1'b0, "R10 restored low");
    step(1'b1, 16'hFFFF, 1'b0, "R10 restored high");

    finished = 1;
    summary();
    $finish;
  end
endmodule